// File: doc/BRIEF.md
# Interrupt Take Qualifier

This block decides, once per clock, whether a processor core should take a hardware interrupt. It holds four small control registers: status, cause, configuration and per-thread control. A single control-register write bus loads them, selected by a 2-bit register index. From those registers and a debug-mode input it forms a global enable condition and a pending test. It then registers the result as one take-interrupt request.

The pending test has two modes, chosen by a configuration bit. In per-line mask mode, each pending bit is its own interrupt line and the matching status bit masks it. In external vectored controller mode, the pending field is read as an unsigned number and the status mask field as a priority level. An interrupt is pending only when the number is strictly above the level. The block does not compute vectors, sequence exception entry or rank individual lines.

Top module: `irq_qualifier`

## Requirements
- R1: While rst_ni is low, irq_o is 0 and all four registers are cleared to 0; after reset, with no writes, irq_o stays 0.
- R2: irq_o can be 1 only when status bit 0 (interrupt enable) is 1.
- R3: Status bit 1 (exception level) set to 1 forces irq_o to 0.
- R4: Status bit 2 (error level) set to 1 forces irq_o to 0.
- R5: debug_mode_i at 1 forces irq_o to 0.
- R6: Thread-control bit 10 (interrupt exempt) set to 1 forces irq_o to 0.
- R7: With configuration bit 6 at 0 (mask mode), the pending test is true when cause[15:8] AND status[15:8] is nonzero.
- R8: With configuration bit 6 at 1 (vectored mode), the pending test is true only when cause[15:8] as an unsigned number is strictly greater than status[15:8]. Equal values, including 0 and 0, give false.
- R9: Changing configuration bit 6 alone switches which pending test applies, with no other register written.
- R10: irq_o is the AND of the enable condition and the pending test, sampled by the clock. A register write at edge N first shows on irq_o after edge N+1.
- R11: Write-bus select codes are 0 status, 1 cause, 2 configuration, 3 thread control. A write with wr_en_i low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 status, 1 cause, 2 config, 3 thread control |
| wr_data_i | input | 32 | Write data |
| debug_mode_i | input | 1 | Core is in debug mode |
| irq_o | output | 1 | Registered take-interrupt request |

## Verification
Any register that holds a wrong value shows up on irq_o one edge after the write settles. A corrupted enable, level or mode bit either raises a request that should be blocked or drops one that should fire. The level comparison in vectored mode is the main exposure. Treating the fields as signed, or using greater-or-equal, changes irq_o on the equal-value and high-bit cases, such as a level of 0x7F against a pending value of 0x80. A missing or doubled output register moves the change on irq_o by one cycle, and the latency checks detect that.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;
  localparam int NUM_REGS   = 4;
  localparam int SEL_W      = $clog2(NUM_REGS);
  localparam int IE_BIT     = 0;
  localparam int EXL_BIT    = 1;
  localparam int ERL_BIT    = 2;
  localparam int VEC_BIT    = 6;
  localparam int EXEMPT_BIT = 10;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_CONFIG = 2'd2,
    SEL_THREAD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 4,
  localparam int SW    = $clog2(NREGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SW-1:0]                wr_sel_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [NREGS-1:0][DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && wr_sel_i == SW'(g)) q <= wr_data_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] thread_i,
  input  logic              debug_mode_i,
  output logic              en_o
);
  import irq_qual_pkg::*;
  always_comb begin
    en_o = status_i[IE_BIT] & ~status_i[EXL_BIT] & ~status_i[ERL_BIT]
         & ~debug_mode_i & ~thread_i[EXEMPT_BIT];
  end
endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval #(
  parameter int PEND_W = 8
) (
  input  logic [PEND_W-1:0] pend_i,
  input  logic [PEND_W-1:0] mask_i,
  input  logic              vec_mode_i,
  output logic              pend_o
);
  logic line_hit, level_hit;
  always_comb begin
    line_hit  = |(pend_i & mask_i);
    level_hit = pend_i > mask_i; // both unsigned
    pend_o    = vec_mode_i ? level_hit : line_hit;
  end
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier #(
  parameter int DATA_W  = 32,
  parameter int PEND_LO = 8,
  parameter int PEND_W  = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [irq_qual_pkg::SEL_W-1:0]   wr_sel_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             debug_mode_i,
  output logic                             irq_o
);
  import irq_qual_pkg::*;
  localparam int PEND_HI = PEND_LO + PEND_W - 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] status_q, cause_q, config_q, thread_q;
  logic en, pend, irq_q;

  irq_state_regs #(.DATA_W(DATA_W), .NREGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .regs_o(regs)
  );

  assign status_q = regs[SEL_STATUS];
  assign cause_q  = regs[SEL_CAUSE];
  assign config_q = regs[SEL_CONFIG];
  assign thread_q = regs[SEL_THREAD];

  irq_enable_gate #(.DATA_W(DATA_W)) u_gate (
    .status_i(status_q), .thread_i(thread_q), .debug_mode_i, .en_o(en)
  );

  irq_pend_eval #(.PEND_W(PEND_W)) u_pend (
    .pend_i(cause_q[PEND_HI:PEND_LO]), .mask_i(status_q[PEND_HI:PEND_LO]),
    .vec_mode_i(config_q[VEC_BIT]), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en & pend;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_qualifier_chk.sv
module irq_qualifier_chk #(
  parameter int DATA_W  = 32,
  parameter int PEND_LO = 8,
  parameter int PEND_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              debug_mode_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] cause_q,
  input logic [DATA_W-1:0] config_q,
  input logic [DATA_W-1:0] thread_q
);
  import irq_qual_pkg::*;
  localparam int PH = PEND_LO + PEND_W - 1;

  always_comb if (!rst_ni) p_reset_low_r1: assert (!irq_o);

  p_ie_needed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(status_q[IE_BIT]) |-> !irq_o);
  p_exl_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_q[EXL_BIT]) |-> !irq_o);
  p_erl_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_q[ERL_BIT]) |-> !irq_o);
  p_dbg_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(debug_mode_i) |-> !irq_o);
  p_exempt_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(thread_q[EXEMPT_BIT]) |-> !irq_o);
  p_mask_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!config_q[VEC_BIT] && (cause_q[PH:PEND_LO] & status_q[PH:PEND_LO]) == '0)
    |-> !irq_o);
  p_level_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(config_q[VEC_BIT] && cause_q[PH:PEND_LO] <= status_q[PH:PEND_LO])
    |-> !irq_o);
  p_fire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_q[IE_BIT] && !status_q[EXL_BIT] && !status_q[ERL_BIT] &&
          !debug_mode_i && !thread_q[EXEMPT_BIT] && config_q[VEC_BIT] &&
          cause_q[PH:PEND_LO] > status_q[PH:PEND_LO]) |-> irq_o);
endmodule

bind irq_qualifier irq_qualifier_chk #(
  .DATA_W(DATA_W), .PEND_LO(PEND_LO), .PEND_W(PEND_W)
) u_chk (
  .clk_i, .rst_ni, .debug_mode_i, .irq_o,
  .status_q, .cause_q, .config_q, .thread_q
);

// File: tb/tb_irq_qualifier.sv
module tb_irq_qualifier;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0, dbg = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_qualifier dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .debug_mode_i(dbg), .irq_o(irq)
  );

  task automatic chk(input logic exp, input string tag);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s: irq_o=%b expected=%b", tag, irq, exp);
    end
  endtask

  // write lands at next posedge; returns at following negedge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle_chk(input logic exp, input string tag);
    @(posedge clk); @(negedge clk); chk(exp, tag);
  endtask

  function automatic logic [31:0] st(input logic [7:0] m, input logic [2:0] lo);
    return {16'h0, m, 5'h0, lo};
  endfunction

  task automatic t_reset;
    chk(1'b0, "R1 during reset");
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 after reset");
  endtask

  task automatic t_mask_mode;
    wr(1, 32'h0000_0400);
    wr(0, st(8'h04, 3'b001));
    chk(1'b0, "R10 no change one edge after write");
    settle_chk(1'b1, "R7 line hit");
    wr(1, 32'h0000_0800);
    settle_chk(1'b0, "R7 line miss");
    wr(1, 32'h0000_0500); wr(0, st(8'h02, 3'b001));
    settle_chk(1'b0, "R7 disjoint bits");
  endtask

  task automatic t_mode_switch;
    wr(2, 32'h40);
    settle_chk(1'b1, "R9 vectored 5>2");
    wr(2, 32'h0);
    settle_chk(1'b0, "R9 back to mask mode");
  endtask

  task automatic t_vectored;
    wr(2, 32'h40);
    wr(0, st(8'h03, 3'b001)); wr(1, 32'h0000_0300);
    settle_chk(1'b0, "R8 equal no fire");
    wr(1, 32'h0000_0400);
    settle_chk(1'b1, "R8 above level");
    wr(0, st(8'h00, 3'b001)); wr(1, 32'h0);
    settle_chk(1'b0, "R8 zero vs zero");
    wr(1, 32'h0000_0100);
    settle_chk(1'b1, "R8 one over zero");
    wr(0, st(8'h7F, 3'b001)); wr(1, 32'h0000_8000);
    settle_chk(1'b1, "R8 unsigned 0x80>0x7F");
    wr(0, st(8'h80, 3'b001)); wr(1, 32'h0000_7F00);
    settle_chk(1'b0, "R8 unsigned 0x7F<0x80");
  endtask

  task automatic t_blockers;
    wr(0, st(8'h10, 3'b001)); wr(1, 32'h0000_2000);
    settle_chk(1'b1, "R10 fire baseline");
    wr(0, st(8'h10, 3'b000)); settle_chk(1'b0, "R2 IE clear");
    wr(0, st(8'h10, 3'b011)); settle_chk(1'b0, "R3 EXL set");
    wr(0, st(8'h10, 3'b101)); settle_chk(1'b0, "R4 ERL set");
    wr(0, st(8'h10, 3'b001)); settle_chk(1'b1, "R10 refire");
    @(negedge clk); dbg = 1'b1;
    @(negedge clk); chk(1'b0, "R5 debug mode");
    dbg = 1'b0;
    @(negedge clk); chk(1'b1, "R5 debug released");
    wr(3, 32'h0000_0400); settle_chk(1'b0, "R6 exempt set");
    wr(3, 32'h0); settle_chk(1'b1, "R6 exempt clear");
  endtask

  task automatic t_no_strobe;
    @(negedge clk); wr_sel = 2'd0; wr_data = 32'h0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(1'b1, "R11 no strobe keeps status");
    @(negedge clk); wr_sel = 2'd3; wr_data = 32'h0000_0400;
    repeat (3) @(negedge clk);
    chk(1'b1, "R11 no strobe keeps thread ctl");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mask_mode();
    t_mode_switch();
    t_vectored();
    t_blockers();
    t_no_strobe();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, done=%b expected=1", done);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule